// File: doc/BRIEF.md
# Key-Shift Change Sequencer

This block takes byte-wide key-control commands and turns them into a safe update of the semitone pitch-shift setting used by a pitch-shifting datapath. One shift value feeds the left, right and mono pitch paths alike. Commands take effect only on a frame boundary, marked by a one-cycle frame strobe. A change between two nonzero shifts is applied at the next boundary. A change that enters or leaves zero shift would interrupt the audio, because the delay memory is used differently. For such a change the block raises a soft-mute request, waits a set number of frames, switches the internal setting, waits again, and then drops the mute.

Two different "off" codes are decoded. One stops key control and gives the delay memory back to other processing. The other stops the shifting but keeps the memory allocated. A command that arrives while a mute sequence runs is held. It is applied after the sequence ends, and a newer command replaces an older held one. The wait lengths are parameters counted in frames. By default they add up to about 46 ms at a 48 kHz frame rate.

Top module: `ksh_seq`

## Requirements
- R1: After reset the shift output is 0, the delay-memory ownership flag is 0 and the mute request is 0.
- R2: A command is accepted only when bits [7:4] of the byte equal 0x2. Bits [3:0] of an accepted byte select the setting: 0x1..0x7 give +1..+7 semitones, 0x9..0xF give -1..-7 semitones, and 0x0 and 0x8 are the two off codes. A byte with any other upper nibble causes no change at any output.
- R3: A command that moves the shift from one nonzero value to another is applied on the first frame strobe after it arrives, with no mute request.
- R4: A command that moves the shift between zero and nonzero raises the mute request on the next frame strobe, with the old setting kept. The new setting is applied MUTE_FRAMES strobes later, and the mute request falls RELEASE_FRAMES strobes after that.
- R5: Off code 0x20 gives shift 0 with ownership 0 (delay memory released). Off code 0x28 gives shift 0 with ownership 1. Any nonzero shift gives ownership 1.
- R6: A change between the two off codes while the shift is already 0 is applied on the next frame strobe without muting.
- R7: Commands that arrive during a mute sequence are held. Only the latest one is applied, starting on the first frame strobe after the mute request falls.
- R8: A command that arrives in the same cycle as the strobe that applies an earlier held command is kept, and is applied on the following strobe.
- R9: The outputs change only in the cycle that follows a frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_tick_i | input | 1 | One-cycle frame boundary strobe |
| cmd_vld_i | input | 1 | Command byte valid |
| cmd_byte_i | input | 8 | Key-control command byte |
| shift_o | output | SHIFT_W | Signed semitone shift for all pitch paths |
| dly_own_o | output | 1 | Key control holds the delay memory |
| mute_req_o | output | 1 | Soft-mute request |

## Verification
Two events can fall in the same cycle: a frame strobe that consumes a held command, and the arrival of a new command. The bench provokes this by raising cmd_vld_i and frame_tick_i together while a command is already pending. It judges the result by expecting two output changes: the older command on that strobe and the newer one on the next strobe. A second overlap happens when a command is held during a mute sequence and itself crosses zero. The bench expects a fresh mute sequence right after the release, with the frame count between events checked at each step.

// File: rtl/ksh_pkg.sv
package ksh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUTE = 2'd1,
        ST_HOLD = 2'd2
    } seq_st_e;

    localparam logic [3:0] KEY_OPCODE = 4'h2;

endpackage

// File: rtl/ksh_cmd_decode.sv
module ksh_cmd_decode #(
    parameter int unsigned SHIFT_W = 4,
    parameter logic [3:0]  OPCODE  = 4'h2
) (
    input  logic [7:0]                cmd_byte_i,
    output logic                      valid_o,
    output logic signed [SHIFT_W-1:0] shift_o,
    output logic                      own_o
);

    logic [3:0]         nib;
    logic [SHIFT_W-1:0] mag;

    always_comb begin
        nib     = cmd_byte_i[3:0];
        valid_o = (cmd_byte_i[7:4] == OPCODE);
        mag     = {{(SHIFT_W-3){1'b0}}, nib[2:0]};
        if (nib[3]) begin
            shift_o = -$signed(mag);
        end else begin
            shift_o = $signed(mag);
        end
        own_o = (nib != 4'h0);
    end

    always_comb begin
        if (valid_o && nib[2:0] == 3'd0) begin
            a_off_zero_r5: assert (shift_o == '0);
        end
    end

endmodule

// File: rtl/ksh_frame_timer.sv
module ksh_frame_timer #(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (tick_i && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
        zero_o = (cnt_q == '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    p_load_taken_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (cnt_q == $past(load_val_i)));

    p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/ksh_seq.sv
module ksh_seq #(
    parameter int unsigned SHIFT_W        = 4,
    parameter int unsigned MUTE_FRAMES    = 1104,
    parameter int unsigned RELEASE_FRAMES = 1104
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      frame_tick_i,
    input  logic                      cmd_vld_i,
    input  logic [7:0]                cmd_byte_i,
    output logic signed [SHIFT_W-1:0] shift_o,
    output logic                      dly_own_o,
    output logic                      mute_req_o
);

    import ksh_pkg::*;

    localparam int unsigned MAX_WAIT = (MUTE_FRAMES > RELEASE_FRAMES) ? MUTE_FRAMES : RELEASE_FRAMES;
    localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);
    localparam logic [CNT_W-1:0] MUTE_LOAD = CNT_W'(MUTE_FRAMES - 1);
    localparam logic [CNT_W-1:0] REL_LOAD  = CNT_W'(RELEASE_FRAMES - 1);

    typedef struct packed {
        seq_st_e                   st;
        logic signed [SHIFT_W-1:0] shift;
        logic                      own;
        logic                      mute;
        logic                      pend_vld;
        logic signed [SHIFT_W-1:0] pend_shift;
        logic                      pend_own;
        logic signed [SHIFT_W-1:0] tgt_shift;
        logic                      tgt_own;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic                      dec_vld;
    logic signed [SHIFT_W-1:0] dec_shift;
    logic                      dec_own;
    logic                      tmr_load;
    logic [CNT_W-1:0]          tmr_val;
    logic                      tmr_zero;
    logic                      take;

    ksh_cmd_decode #(
        .SHIFT_W (SHIFT_W),
        .OPCODE  (KEY_OPCODE)
    ) u_dec (
        .cmd_byte_i (cmd_byte_i),
        .valid_o    (dec_vld),
        .shift_o    (dec_shift),
        .own_o      (dec_own)
    );

    ksh_frame_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .tick_i     (frame_tick_i),
        .zero_o     (tmr_zero)
    );

    always_comb begin
        s_d      = s_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        take     = 1'b0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (frame_tick_i && s_q.pend_vld) begin
                    take = 1'b1;
                    if ((s_q.pend_shift == '0) != (s_q.shift == '0)) begin
                        s_d.st        = ST_MUTE;
                        s_d.mute      = 1'b1;
                        s_d.tgt_shift = s_q.pend_shift;
                        s_d.tgt_own   = s_q.pend_own;
                        tmr_load      = 1'b1;
                        tmr_val       = MUTE_LOAD;
                    end else begin
                        s_d.shift = s_q.pend_shift;
                        s_d.own   = s_q.pend_own;
                    end
                end
            end
            ST_MUTE: begin
                if (frame_tick_i && tmr_zero) begin
                    s_d.shift = s_q.tgt_shift;
                    s_d.own   = s_q.tgt_own;
                    s_d.st    = ST_HOLD;
                    tmr_load  = 1'b1;
                    tmr_val   = REL_LOAD;
                end
            end
            ST_HOLD: begin
                if (frame_tick_i && tmr_zero) begin
                    s_d.mute = 1'b0;
                    s_d.st   = ST_IDLE;
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase

        if (take) begin
            s_d.pend_vld = 1'b0;
        end
        if (cmd_vld_i && dec_vld) begin
            s_d.pend_vld   = 1'b1;
            s_d.pend_shift = dec_shift;
            s_d.pend_own   = dec_own;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{st: ST_IDLE, shift: '0, own: 1'b0, mute: 1'b0,
                     pend_vld: 1'b0, pend_shift: '0, pend_own: 1'b0,
                     tgt_shift: '0, tgt_own: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign shift_o    = s_q.shift;
    assign dly_own_o  = s_q.own;
    assign mute_req_o = s_q.mute;

    p_cross_muted_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((shift_o == '0) != $past(shift_o == '0)) |-> (mute_req_o && $past(mute_req_o)));

    p_seq_mutes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.st != ST_IDLE) |-> mute_req_o);

    p_tick_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable({shift_o, dly_own_o, mute_req_o}) |-> $past(frame_tick_i));

    p_released_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dly_own_o |-> (shift_o == '0));

    p_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift_o <= 7) && (shift_o >= -7));

endmodule

// File: tb/ksh_seq_tb_top.sv
module ksh_seq_tb_top;

    localparam int M = 3;
    localparam int U = 2;

    typedef struct {
        int s;
        bit o;
        bit m;
        int gap;
        string req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              cvld = 1'b0;
    logic [7:0]        cbyte = 8'h00;
    logic signed [3:0] shift;
    logic              own;
    logic              mute;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   tick_cnt = 0;
    int   last_evt = 0;
    bit   done = 0;

    always #2 clk = ~clk;

    ksh_seq #(
        .SHIFT_W        (4),
        .MUTE_FRAMES    (M),
        .RELEASE_FRAMES (U)
    ) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .frame_tick_i (tick),
        .cmd_vld_i    (cvld),
        .cmd_byte_i   (cbyte),
        .shift_o      (shift),
        .dly_own_o    (own),
        .mute_req_o   (mute)
    );

    task automatic push(int s, bit o, bit m, int gap, string req);
        exp_t e;
        e.s = s; e.o = o; e.m = m; e.gap = gap; e.req = req;
        q.push_back(e);
    endtask

    task automatic push_cross(int os, bit oo, int ns, bit no, string req);
        push(os, oo, 1, -1, req);
        push(ns, no, 1, M, req);
        push(ns, no, 0, U, req);
    endtask

    task automatic send(logic [7:0] b);
        @(negedge clk);
        cvld = 1'b1; cbyte = b;
        @(negedge clk);
        cvld = 1'b0;
    endtask

    task automatic pulse(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic send_with_tick(logic [7:0] b);
        @(negedge clk);
        cvld = 1'b1; cbyte = b; tick = 1'b1;
        @(negedge clk);
        cvld = 1'b0; tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic check_now(int s, bit o, bit m, string req);
        @(negedge clk);
        checks++;
        if (shift !== 4'(s) || own !== o || mute !== m) begin
            errors++;
            $display("FAIL %s: got shift=%0d own=%0b mute=%0b, expected shift=%0d own=%0b mute=%0b",
                     req, shift, own, mute, s, o, m);
        end
    endtask

    // monitor: sample just after each rising edge, compare each output change
    initial begin
        logic signed [3:0] ps;
        logic po, pm;
        exp_t e;
        ps = 0; po = 0; pm = 0;
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (tick) tick_cnt++;
                if (shift !== ps || own !== po || mute !== pm) begin
                    checks++;
                    if (!tick) begin
                        errors++;
                        $display("FAIL R9: output change without frame strobe, got shift=%0d expected no change", shift);
                    end
                    if (q.size() == 0) begin
                        errors++;
                        $display("FAIL R2: unexpected change shift=%0d own=%0b mute=%0b, expected none",
                                 shift, own, mute);
                    end else begin
                        e = q.pop_front();
                        if (shift !== 4'(e.s) || own !== e.o || mute !== e.m ||
                            (e.gap >= 0 && tick_cnt - last_evt != e.gap)) begin
                            errors++;
                            $display("FAIL %s: got shift=%0d own=%0b mute=%0b gap=%0d, expected shift=%0d own=%0b mute=%0b gap=%0d",
                                     e.req, shift, own, mute, tick_cnt - last_evt, e.s, e.o, e.m, e.gap);
                        end
                    end
                    last_evt = tick_cnt;
                end
            end
            ps = shift; po = own; pm = mute;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_now(0, 0, 0, "R1");

        // zero -> +3 crosses zero
        push_cross(0, 0, 3, 1, "R4");
        send(8'h23);
        pulse(1 + M + U);
        check_now(3, 1, 0, "R4");

        // no strobe, no change
        push(5, 1, 0, -1, "R3");
        send(8'h25);
        repeat (8) @(negedge clk);
        check_now(3, 1, 0, "R9");
        pulse(1);
        check_now(5, 1, 0, "R3");

        push(-4, 1, 0, -1, "R3");
        send(8'h2C);
        pulse(1);
        check_now(-4, 1, 0, "R2");

        // foreign opcodes ignored
        send(8'h45);
        send(8'h30);
        send(8'hA8);
        pulse(2);
        check_now(-4, 1, 0, "R2");

        // off keeping memory: crossing
        push_cross(-4, 1, 0, 1, "R5");
        send(8'h28);
        pulse(1 + M + U);
        check_now(0, 1, 0, "R5");

        // switch between off codes at zero: direct
        push(0, 0, 0, 1, "R6");
        send(8'h20);
        pulse(1);
        check_now(0, 0, 0, "R5");
        push(0, 1, 0, 1, "R6");
        send(8'h28);
        pulse(1);
        push(0, 0, 0, 1, "R6");
        send(8'h20);
        pulse(1);
        check_now(0, 0, 0, "R6");

        // held commands during sequence, latest wins
        push_cross(0, 0, 7, 1, "R7");
        push(-7, 1, 0, 1, "R7");
        send(8'h27);
        pulse(1);
        send(8'h21);
        send(8'h2F);
        pulse(M + U);
        check_now(7, 1, 0, "R7");
        pulse(1);
        check_now(-7, 1, 0, "R7");

        // same-cycle arrival and consumption
        push(2, 1, 0, -1, "R8");
        push(-2, 1, 0, 1, "R8");
        send(8'h22);
        send_with_tick(8'h2A);
        check_now(2, 1, 0, "R8");
        pulse(1);
        check_now(-2, 1, 0, "R8");

        // held command that itself crosses zero
        push_cross(-2, 1, 0, 0, "R7");
        push_cross(0, 0, 6, 1, "R7");
        send(8'h20);
        pulse(1);
        send(8'h26);
        pulse(M + U);
        check_now(0, 0, 0, "R5");
        pulse(1 + M + U);
        check_now(6, 1, 0, "R7");

        repeat (4) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R4: %0d expected changes never seen, expected 0", q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule